// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Control

This block decides, every cycle, how a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back) copes with dependencies between instructions in flight. It looks at the register numbers held in the pipeline registers, the write enables and load flags of the older instructions, and the outcome of the branch comparison in decode. From these it selects where each execute-stage operand comes from and where each decode-comparator operand comes from. It also decides when fetch and decode must hold while a bubble enters execute, and when the instruction fetched behind a taken branch must be squashed.

The register file writes early in a cycle and reads late, so a value being written back is already visible to decode. For that reason the decode comparator never needs a write-back bypass. Branches are predicted not taken and resolved in decode. All outputs are combinational functions of the current inputs, and the surrounding datapath applies them at its next clock edge.

Top module: `hz_ctrl`

## Requirements
- R1: Execute operand selects use the encoding 0 = register file, 1 = memory-stage result, 2 = write-back result, and never take the value 3. When both the memory stage and the write-back stage target the operand's register, the select is 1.
- R2: When only the write-back stage writes an execute operand's register, that operand's select is 2.
- R3: Register 0 is never a bypass source. A source or destination of 0 gives select 0 and causes no stall.
- R4: A load in execute with write enable set, whose destination is a decode source, raises stall_pc, stall_ifid and bubble_idex together. With the write enable clear, there is no stall.
- R5: A branch in decode whose source is written by a non-load in execute stalls. A non-branch in the same situation does not stall.
- R6: A branch in decode whose source is written by a load in the memory stage stalls. Together with R4, a load followed by a dependent branch therefore stalls for two cycles.
- R7: A decode comparator select is 1 (memory-stage result) when a non-load in the memory stage writes that source register. Otherwise it is 0, including when only write-back writes that register.
- R8: flush_ifid is 1 only for a branch in decode that is taken while no stall is raised. A stall in the same cycle suppresses the flush.
- R9: Without a write enable, or with no register match, every select is 0, and no stall and no flush are raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | RW | First source register of the instruction in decode |
| id_rs2 | input | RW | Second source register of the instruction in decode |
| id_is_branch | input | 1 | Instruction in decode is a conditional branch |
| id_br_taken | input | 1 | Decode comparator reports the branch taken |
| ex_rs1 | input | RW | First source register of the instruction in execute |
| ex_rs2 | input | RW | Second source register of the instruction in execute |
| ex_rd | input | RW | Destination register of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | RW | Destination register of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| mem_is_load | input | 1 | Instruction in memory is a load |
| wb_rd | input | RW | Destination register of the instruction in write-back |
| wb_wen | input | 1 | Instruction in write-back writes a register |
| ex_fwd_a | output | 2 | Source select for execute operand A |
| ex_fwd_b | output | 2 | Source select for execute operand B |
| id_fwd_a | output | 1 | Source select for comparator operand A |
| id_fwd_b | output | 1 | Source select for comparator operand B |
| stall_pc | output | 1 | Hold the program counter |
| stall_ifid | output | 1 | Hold the fetch/decode register |
| bubble_idex | output | 1 | Clear control fields entering execute |
| flush_ifid | output | 1 | Squash the instruction in the fetch/decode register |

## Verification
Every result of this block is due in the same cycle as the pipeline-register contents that cause it, because no register lies between the inputs and the outputs. The driver applies each stimulus just after a rising edge and queues the expected values. The monitor pops and compares them at the following falling edge, half a period later, when the stimulus has settled and before the next one is applied. The two-cycle load-then-branch stall is checked as two consecutive stimuli: the load in execute, then the load in the memory stage.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    BYP_RF  = 2'd0,
    BYP_MEM = 2'd1,
    BYP_WB  = 2'd2
  } byp_e;

  // A producer feeds a consumer only if it writes, targets a real register
  // (register 0 is hardwired) and that register is the consumer's source.
  function automatic logic reg_hit(input logic [31:0] rd, input logic wen,
                                   input logic [31:0] rs);
    return wen && (rd != 32'd0) && (rd == rs);
  endfunction

  // Memory stage is younger than write-back, so it wins.
  function automatic byp_e pick_ex_src(input logic hit_mem, input logic hit_wb);
    if (hit_mem)     return BYP_MEM;
    else if (hit_wb) return BYP_WB;
    else             return BYP_RF;
  endfunction
endpackage

// File: rtl/hz_ex_bypass.sv
module hz_ex_bypass import hz_pkg::*; #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  output byp_e          sel
);
  logic hit_mem, hit_wb;

  assign hit_mem = reg_hit(32'(mem_rd), mem_wen, 32'(src));
  assign hit_wb  = reg_hit(32'(wb_rd), wb_wen, 32'(src));
  assign sel     = pick_ex_src(hit_mem, hit_wb);

  always_comb begin
    p_sel_legal_r1: assert (sel != 2'd3) else $error("illegal select");
    p_zero_src_r3: assert (src != '0 || sel == BYP_RF) else $error("r0 bypassed");
  end
endmodule

// File: rtl/hz_id_bypass.sv
module hz_id_bypass import hz_pkg::*; #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  output logic          sel_mem
);
  // Load data is not ready until the end of memory access; write-back needs
  // no path because the register file writes before it is read.
  assign sel_mem = reg_hit(32'(mem_rd), mem_wen, 32'(src)) && !mem_is_load;

  always_comb begin
    p_no_load_byp_r7: assert (!(sel_mem && mem_is_load)) else $error("load bypassed to decode");
  end
endmodule

// File: rtl/hz_stall_detect.sv
module hz_stall_detect import hz_pkg::*; #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_is_branch,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  output logic          load_use_hit,
  output logic          br_ex_hit,
  output logic          br_memld_hit
);
  logic ex_dep, mem_dep;

  assign ex_dep  = reg_hit(32'(ex_rd), ex_wen, 32'(id_rs1)) ||
                   reg_hit(32'(ex_rd), ex_wen, 32'(id_rs2));
  assign mem_dep = reg_hit(32'(mem_rd), mem_wen, 32'(id_rs1)) ||
                   reg_hit(32'(mem_rd), mem_wen, 32'(id_rs2));

  // Any consumer of a load one behind it waits one cycle.
  assign load_use_hit = ex_dep && ex_is_load;
  // A branch compares in decode, so an ALU result still in execute is late.
  assign br_ex_hit    = ex_dep && !ex_is_load && id_is_branch;
  // Second cycle of a load-then-branch dependency.
  assign br_memld_hit = mem_dep && mem_is_load && id_is_branch;

  always_comb begin
    p_hits_excl_r5: assert (!(load_use_hit && br_ex_hit)) else $error("overlapping hits");
    p_br_only_r6: assert (id_is_branch || !br_memld_hit) else $error("non-branch mem stall");
  end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl import hz_pkg::*; #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_rs1,
  input  logic [RW-1:0] id_rs2,
  input  logic          id_is_branch,
  input  logic          id_br_taken,
  input  logic [RW-1:0] ex_rs1,
  input  logic [RW-1:0] ex_rs2,
  input  logic [RW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_is_load,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic          id_fwd_a,
  output logic          id_fwd_b,
  output logic          stall_pc,
  output logic          stall_ifid,
  output logic          bubble_idex,
  output logic          flush_ifid
);
  localparam int NSRC = 2;

  logic [RW-1:0] ex_src [NSRC];
  logic [RW-1:0] id_src [NSRC];
  byp_e          ex_sel [NSRC];
  logic          id_sel [NSRC];

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;
  assign id_src[0] = id_rs1;
  assign id_src[1] = id_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_ex_bypass #(.RW(RW)) u_exb (
      .src(ex_src[g]), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(ex_sel[g])
    );
    hz_id_bypass #(.RW(RW)) u_idb (
      .src(id_src[g]), .mem_rd(mem_rd), .mem_wen(mem_wen),
      .mem_is_load(mem_is_load), .sel_mem(id_sel[g])
    );
  end

  assign ex_fwd_a = ex_sel[0];
  assign ex_fwd_b = ex_sel[1];
  assign id_fwd_a = id_sel[0];
  assign id_fwd_b = id_sel[1];

  // Named internal events, visible to the assertions below.
  logic load_use_hit, br_ex_hit, br_memld_hit, stall_any, br_redirect;

  hz_stall_detect #(.RW(RW)) u_stall (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_branch(id_is_branch),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .load_use_hit(load_use_hit), .br_ex_hit(br_ex_hit),
    .br_memld_hit(br_memld_hit)
  );

  assign stall_any   = load_use_hit || br_ex_hit || br_memld_hit;
  assign br_redirect = id_is_branch && id_br_taken;

  assign stall_pc    = stall_any;
  assign stall_ifid  = stall_any;
  assign bubble_idex = stall_any;
  // An unresolved branch must not redirect: the stall wins.
  assign flush_ifid  = br_redirect && !stall_any;

  always_comb begin
    p_loaduse_r4: assert (!load_use_hit || (stall_pc && stall_ifid && bubble_idex))
      else $error("load-use not stalled");
    p_br_ex_r5: assert (!br_ex_hit || stall_pc) else $error("branch on ex not stalled");
    p_br_memld_r6: assert (!br_memld_hit || bubble_idex) else $error("branch on load not stalled");
    p_stall_wins_r8: assert (!(flush_ifid && stall_ifid)) else $error("flush during stall");
    p_flush_cause_r8: assert (!flush_ifid || br_redirect) else $error("flush without branch");
  end
endmodule

// File: tb/sim_hz_ctrl.sv
module sim_hz_ctrl;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [RW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_is_branch, id_br_taken, ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen;
  logic [1:0] ex_fwd_a, ex_fwd_b;
  logic id_fwd_a, id_fwd_b, stall_pc, stall_ifid, bubble_idex, flush_ifid;

  hz_ctrl #(.RW(RW)) u0 (.*);

  typedef struct {
    string      tag;
    logic [1:0] exa, exb;
    logic       ida, idb, stall, flush;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit summary_done = 0;

  task automatic drive(string tag,
                       logic [RW-1:0] irs1, logic [RW-1:0] irs2, logic br, logic tk,
                       logic [RW-1:0] ers1, logic [RW-1:0] ers2, logic [RW-1:0] erd,
                       logic ew, logic el,
                       logic [RW-1:0] mrd, logic mw, logic ml,
                       logic [RW-1:0] wrd, logic ww,
                       logic [1:0] e_exa, logic [1:0] e_exb, logic e_ida, logic e_idb,
                       logic e_stall, logic e_flush);
    exp_t e;
    @(posedge clk);
    #1;
    id_rs1 = irs1; id_rs2 = irs2; id_is_branch = br; id_br_taken = tk;
    ex_rs1 = ers1; ex_rs2 = ers2; ex_rd = erd; ex_wen = ew; ex_is_load = el;
    mem_rd = mrd; mem_wen = mw; mem_is_load = ml; wb_rd = wrd; wb_wen = ww;
    e.tag = tag; e.exa = e_exa; e.exb = e_exb; e.ida = e_ida; e.idb = e_idb;
    e.stall = e_stall; e.flush = e_flush;
    q.push_back(e);
  endtask

  task automatic cmp1(string tag, string name, logic [1:0] act, logic [1:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
    end
  endtask

  // Monitor: half a period after each stimulus.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      cmp1(e.tag, "ex_fwd_a", ex_fwd_a, e.exa);
      cmp1(e.tag, "ex_fwd_b", ex_fwd_b, e.exb);
      cmp1(e.tag, "id_fwd_a", {1'b0, id_fwd_a}, {1'b0, e.ida});
      cmp1(e.tag, "id_fwd_b", {1'b0, id_fwd_b}, {1'b0, e.idb});
      cmp1(e.tag, "stall_pc", {1'b0, stall_pc}, {1'b0, e.stall});
      cmp1(e.tag, "stall_ifid", {1'b0, stall_ifid}, {1'b0, e.stall});
      cmp1(e.tag, "bubble_idex", {1'b0, bubble_idex}, {1'b0, e.stall});
      cmp1(e.tag, "flush_ifid", {1'b0, flush_ifid}, {1'b0, e.flush});
    end
  end

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
    end
  endtask

  initial begin
    // args: tag, id_rs1,id_rs2,br,taken, ex_rs1,ex_rs2,ex_rd,ex_wen,ex_ld,
    //       mem_rd,mem_wen,mem_ld, wb_rd,wb_wen, exp exa,exb,ida,idb,stall,flush
    drive("R9 idle",          0,0,0,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0,0,0,0,0);
    drive("R1 mem priority",  0,0,0,0, 5,7,0,0,0, 5,1,0, 5,1, 1,0,0,0,0,0);
    drive("R2 wb select",     0,0,0,0, 3,4,0,0,0, 4,1,0, 3,1, 2,1,0,0,0,0);
    drive("R3 reg zero",      0,0,0,0, 0,0,0,1,1, 0,1,0, 0,1, 0,0,0,0,0,0);
    drive("R9 no wen",        0,0,0,0, 8,8,0,0,0, 8,0,0, 8,0, 0,0,0,0,0,0);
    drive("R4 load-use",      1,9,0,0, 0,0,9,1,1, 0,0,0, 0,0, 0,0,0,0,1,0);
    drive("R4 load no wen",   1,9,0,0, 0,0,9,0,1, 0,0,0, 0,0, 0,0,0,0,0,0);
    drive("R5 non-branch",    9,2,0,0, 0,0,9,1,0, 0,0,0, 0,0, 0,0,0,0,0,0);
    drive("R5 branch on ex",  9,2,1,1, 0,0,9,1,0, 0,0,0, 0,0, 0,0,0,0,1,0);
    drive("R6 ld-br cycle1",  2,12,1,0, 0,0,12,1,1, 0,0,0, 0,0, 0,0,0,0,1,0);
    drive("R6 ld-br cycle2",  2,12,1,0, 0,0,0,0,0, 12,1,1, 0,0, 0,0,0,0,1,0);
    drive("R7 dec bypass",    12,3,1,1, 0,0,0,0,0, 12,1,0, 0,0, 0,0,1,0,0,1);
    drive("R7 wb no bypass",  14,14,1,0, 0,0,0,0,0, 0,0,0, 14,1, 0,0,0,0,0,0);
    drive("R8 taken flush",   4,5,1,1, 0,0,0,0,0, 0,0,0, 0,0, 0,0,0,0,0,1);
    drive("R8 not taken",     4,5,1,0, 0,0,0,0,0, 0,0,0, 0,0, 0,0,0,0,0,0);
    drive("R8 taken no br",   4,5,0,1, 0,0,0,0,0, 0,0,0, 0,0, 0,0,0,0,0,0);
    drive("R1 both operands", 0,0,0,0, 6,6,0,0,0, 6,1,1, 6,1, 1,1,0,0,0,0);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule